// File: doc/BRIEF.md
# Edge/Level Interrupt Controller

This block collects interrupt requests from a bank of 32 peripheral lines and folds them into one registered request to the CPU. A bank can be set up at build time, through a mask parameter, so that some of its lines count as level-type and all the others as edge-type. When an edge-type line goes from low to high, the block records the event in a sticky state bit. A level-type line is never latched. It stays pending only while its input is high and its enable bit is set. Software reads the live line values, programs an enable mask, and drops recorded events by writing ones to a clear register.

A second bank of 32 lines can be added by parameter. Every line in that bank is edge-type. A downstream controller can be chained in through a dedicated cascade input, which is ORed onto one chosen line of the low bank. That line's enable bit cannot be cleared, so chained requests always get through. Every input passes through a synchroniser before it is used. Register access is over a simple synchronous bus with one cycle of read latency.

Top module: `edgelvl_irqc`

## Requirements
- R1: Out of reset, every state bit, level bit and enable bit of both banks is zero, except the enable bit of the cascade line (bit 28), and cpu_irq_o is low.
- R2: A rising edge on an edge-type line sets that line's state bit whether or not the line is enabled, and the bit stays set after the line falls. Level-type positions (bits 20 to 28 of the low bank by default) always read 0 in the state register.
- R3: A write to the clear register clears every state bit whose wdata bit is 1 and leaves the bits whose wdata bit is 0 unchanged. The low-bank clear register is at offset 0x28 and the high-bank one at 0x18.
- R4: If a clear write for a line lands in the same cycle that a new rising edge on that line is latched, the state bit ends up set.
- R5: The level register reads the synchronised input values of all lines (low bank at 0x2c, high bank at 0x1c). A level-type line raises the CPU request only while it is high and enabled, and the request drops when the line falls.
- R6: cpu_irq_o is a registered OR of all pending lines. Pending means state AND enable for edge-type lines and level AND enable for level-type lines. Removing the enable bit drops the request without clearing the state bit.
- R7: The enable register is read/write, at offset 0x24 for the low bank and 0x14 for the high bank. A write replaces its whole contents.
- R8: The high bank has its state, enable, clear and level registers at offsets 0x10, 0x14, 0x18 and 0x1c. All of its lines are edge-type, including those whose low-bank position would be level-type, and its pending lines drive cpu_irq_o.
- R9: cascade_i is ORed onto low-bank line 28 ahead of the synchroniser. The enable bit of that line reads 1 after any enable write.
- R10: A read returns its data on bus_rdata_o one cycle after the request. Clear registers and unmapped offsets read 0. bus_rdata_o is 0 in any cycle after which no read was made. Writes to state, level or unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lo_i | input | 32 | Low-bank request lines (asynchronous) |
| irq_hi_i | input | 32 | High-bank request lines (asynchronous) |
| cascade_i | input | 1 | Request from a chained downstream controller |
| bus_valid_i | input | 1 | Bus access strobe |
| bus_write_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read |
| cpu_irq_o | output | 1 | Registered interrupt request to the CPU |

## Verification
The bench times a clear write to land in the exact cycle a fresh edge is latched. A design that lets the clear win would lose that interrupt. It also checks that a masked edge is still recorded, so that a design gating the latch with the enable bit would miss a request that arrives before software unmasks the line. Level lines are dropped and checked to make sure the CPU request falls with them and is not latched. A high-bank line at a position that is level-type in the low bank is pulsed to catch a design that applies the low mask to both banks. Finally, the bench writes zero to the enable register and confirms the cascade line stays enabled, which a design without the forced bit would fail by blocking chained requests.

// File: rtl/eli_pkg.sv
package eli_pkg;

   // Register offsets. The decode depends on these values, so they are fixed.
   localparam logic [7:0] OFS_HI_STATE = 8'h10;
   localparam logic [7:0] OFS_HI_EN    = 8'h14;
   localparam logic [7:0] OFS_HI_CLR   = 8'h18;
   localparam logic [7:0] OFS_HI_LVL   = 8'h1c;
   localparam logic [7:0] OFS_LO_STATE = 8'h20;
   localparam logic [7:0] OFS_LO_EN    = 8'h24;
   localparam logic [7:0] OFS_LO_CLR   = 8'h28;
   localparam logic [7:0] OFS_LO_LVL   = 8'h2c;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_STATE,
      SEL_EN,
      SEL_CLR,
      SEL_LVL
   } reg_sel_e;

   typedef struct packed {
      logic     hi;
      reg_sel_e sel;
   } reg_dec_t;

   function automatic reg_dec_t decode_ofs(input logic [7:0] ofs,
                                           input logic upper_zero,
                                           input logic has_hi);
      reg_dec_t d;
      d.hi  = 1'b0;
      d.sel = SEL_NONE;
      if (upper_zero) begin
         case (ofs)
            OFS_LO_STATE: d.sel = SEL_STATE;
            OFS_LO_EN:    d.sel = SEL_EN;
            OFS_LO_CLR:   d.sel = SEL_CLR;
            OFS_LO_LVL:   d.sel = SEL_LVL;
            OFS_HI_STATE: begin d.hi = 1'b1; d.sel = has_hi ? SEL_STATE : SEL_NONE; end
            OFS_HI_EN:    begin d.hi = 1'b1; d.sel = has_hi ? SEL_EN    : SEL_NONE; end
            OFS_HI_CLR:   begin d.hi = 1'b1; d.sel = has_hi ? SEL_CLR   : SEL_NONE; end
            OFS_HI_LVL:   begin d.hi = 1'b1; d.sel = has_hi ? SEL_LVL   : SEL_NONE; end
            default:      d.sel = SEL_NONE;
         endcase
      end
      return d;
   endfunction

endpackage

// File: rtl/eli_sync.sv
module eli_sync #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("eli_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] stg_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stg_q <= '0;
      end else begin
         stg_q <= {stg_q[STAGES-2:0], d_i};
      end
   end

   assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/eli_bank.sv
module eli_bank #(
   parameter int unsigned   W        = 32,
   parameter logic [W-1:0]  LVL_MASK = '0,
   parameter logic [W-1:0]  KEEP_EN  = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl_i,
   input  logic         en_we_i,
   input  logic         clr_we_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] state_o,
   output logic [W-1:0] enable_o,
   output logic [W-1:0] level_o,
   output logic         pend_o
);

   localparam logic [W-1:0] EDGE_MASK = ~LVL_MASK;

   logic [W-1:0] prev_q;
   logic [W-1:0] state_q;
   logic [W-1:0] en_q;
   logic [W-1:0] rise;
   logic [W-1:0] clr_bits;
   logic [W-1:0] pend_vec;

   assign rise     = lvl_i & ~prev_q & EDGE_MASK;
   assign clr_bits = clr_we_i ? wdata_i : '0;

   // A newly latched edge wins over a clear in the same cycle.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q  <= '0;
         state_q <= '0;
         en_q    <= KEEP_EN;
      end else begin
         prev_q  <= lvl_i;
         state_q <= (state_q & ~clr_bits) | rise;
         if (en_we_i) begin
            en_q <= wdata_i | KEEP_EN;
         end
      end
   end

   for (genvar i = 0; i < W; i++) begin : g_line
      if (LVL_MASK[i]) begin : g_level
         assign pend_vec[i] = lvl_i[i] & en_q[i];
      end else begin : g_edge
         assign pend_vec[i] = state_q[i] & en_q[i];
      end
   end

   assign pend_o   = |pend_vec;
   assign state_o  = state_q;
   assign enable_o = en_q;
   assign level_o  = lvl_i;

endmodule

// File: rtl/eli_regif.sv
module eli_regif
   import eli_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned W      = 32,
   parameter bit          HAS_HI = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_i,
   input  logic              write_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [W-1:0]      st_lo_i,
   input  logic [W-1:0]      en_lo_i,
   input  logic [W-1:0]      lv_lo_i,
   input  logic [W-1:0]      st_hi_i,
   input  logic [W-1:0]      en_hi_i,
   input  logic [W-1:0]      lv_hi_i,
   output logic              en_we_lo_o,
   output logic              clr_we_lo_o,
   output logic              en_we_hi_o,
   output logic              clr_we_hi_o,
   output logic [W-1:0]      rdata_o
);

   if (ADDR_W < 8) begin : g_bad_addr
      $error("eli_regif: ADDR_W must be at least 8");
   end

   logic         upper_zero;
   reg_dec_t     dec;
   logic         wr;
   logic         rd;
   logic [W-1:0] rd_mux;
   logic [W-1:0] rdata_q;

   assign upper_zero = ((addr_i >> 8) == '0);
   assign dec        = decode_ofs(addr_i[7:0], upper_zero, HAS_HI);
   assign wr         = valid_i & write_i;
   assign rd         = valid_i & ~write_i;

   assign en_we_lo_o  = wr & ~dec.hi & (dec.sel == SEL_EN);
   assign clr_we_lo_o = wr & ~dec.hi & (dec.sel == SEL_CLR);
   assign en_we_hi_o  = wr &  dec.hi & (dec.sel == SEL_EN);
   assign clr_we_hi_o = wr &  dec.hi & (dec.sel == SEL_CLR);

   always_comb begin
      rd_mux = '0;
      unique case (dec.sel)
         SEL_STATE: rd_mux = dec.hi ? st_hi_i : st_lo_i;
         SEL_EN:    rd_mux = dec.hi ? en_hi_i : en_lo_i;
         SEL_LVL:   rd_mux = dec.hi ? lv_hi_i : lv_lo_i;
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else begin
         rdata_q <= rd ? rd_mux : '0;
      end
   end

   assign rdata_o = rdata_q;

endmodule

// File: rtl/edgelvl_irqc.sv
module edgelvl_irqc #(
   parameter int unsigned        LINES         = 32,
   parameter int unsigned        ADDR_W        = 8,
   parameter int unsigned        SYNC_STAGES   = 2,
   parameter bit                 HAS_HIGH_BANK = 1'b1,
   parameter logic [LINES-1:0]   LEVEL_MASK    = 32'h1ff0_0000,
   parameter bit                 CASCADE_EN    = 1'b1,
   parameter int unsigned        CASCADE_LINE  = 28
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LINES-1:0]  irq_lo_i,
   input  logic [LINES-1:0]  irq_hi_i,
   input  logic              cascade_i,
   input  logic              bus_valid_i,
   input  logic              bus_write_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [LINES-1:0]  bus_wdata_i,
   output logic [LINES-1:0]  bus_rdata_o,
   output logic              cpu_irq_o
);

   if (LINES < 1 || LINES > 32) begin : g_bad_lines
      $error("edgelvl_irqc: LINES must be in 1..32");
   end
   if (CASCADE_LINE >= LINES) begin : g_bad_casc
      $error("edgelvl_irqc: CASCADE_LINE out of range");
   end

   localparam logic [LINES-1:0] CASC_MASK =
      CASCADE_EN ? (LINES'(1) << CASCADE_LINE) : '0;

   logic [LINES-1:0] lo_raw;
   logic [LINES-1:0] lo_sync;
   logic [LINES-1:0] st_lo, en_lo, lv_lo;
   logic [LINES-1:0] st_hi, en_hi, lv_hi;
   logic             pend_lo, pend_hi;
   logic             en_we_lo, clr_we_lo, en_we_hi, clr_we_hi;
   logic             irq_q;

   assign lo_raw = irq_lo_i | (CASC_MASK & {LINES{cascade_i}});

   eli_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync_lo (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (lo_raw),
      .q_o   (lo_sync)
   );

   eli_bank #(.W(LINES), .LVL_MASK(LEVEL_MASK), .KEEP_EN(CASC_MASK)) u_bank_lo (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl_i    (lo_sync),
      .en_we_i  (en_we_lo),
      .clr_we_i (clr_we_lo),
      .wdata_i  (bus_wdata_i),
      .state_o  (st_lo),
      .enable_o (en_lo),
      .level_o  (lv_lo),
      .pend_o   (pend_lo)
   );

   if (HAS_HIGH_BANK) begin : g_hi
      logic [LINES-1:0] hi_sync;

      eli_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync_hi (
         .clk   (clk),
         .rst_n (rst_n),
         .d_i   (irq_hi_i),
         .q_o   (hi_sync)
      );

      eli_bank #(.W(LINES), .LVL_MASK('0), .KEEP_EN('0)) u_bank_hi (
         .clk      (clk),
         .rst_n    (rst_n),
         .lvl_i    (hi_sync),
         .en_we_i  (en_we_hi),
         .clr_we_i (clr_we_hi),
         .wdata_i  (bus_wdata_i),
         .state_o  (st_hi),
         .enable_o (en_hi),
         .level_o  (lv_hi),
         .pend_o   (pend_hi)
      );
   end else begin : g_no_hi
      assign st_hi   = '0;
      assign en_hi   = '0;
      assign lv_hi   = '0;
      assign pend_hi = 1'b0;
   end

   eli_regif #(.ADDR_W(ADDR_W), .W(LINES), .HAS_HI(HAS_HIGH_BANK)) u_regif (
      .clk         (clk),
      .rst_n       (rst_n),
      .valid_i     (bus_valid_i),
      .write_i     (bus_write_i),
      .addr_i      (bus_addr_i),
      .st_lo_i     (st_lo),
      .en_lo_i     (en_lo),
      .lv_lo_i     (lv_lo),
      .st_hi_i     (st_hi),
      .en_hi_i     (en_hi),
      .lv_hi_i     (lv_hi),
      .en_we_lo_o  (en_we_lo),
      .clr_we_lo_o (clr_we_lo),
      .en_we_hi_o  (en_we_hi),
      .clr_we_hi_o (clr_we_hi),
      .rdata_o     (bus_rdata_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
      end else begin
         irq_q <= pend_lo | pend_hi;
      end
   end

   assign cpu_irq_o = irq_q;

endmodule

// File: rtl/eli_checker.sv
module eli_checker
   import eli_pkg::*;
#(
   parameter int unsigned      LINES     = 32,
   parameter int unsigned      ADDR_W    = 8,
   parameter logic [LINES-1:0] CASC_MASK = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_valid_i,
   input logic              bus_write_i,
   input logic [ADDR_W-1:0] bus_addr_i,
   input logic [LINES-1:0]  bus_wdata_i,
   input logic [LINES-1:0]  bus_rdata_o,
   input logic              cpu_irq_o,
   input logic [LINES-1:0]  st_lo,
   input logic [LINES-1:0]  en_lo
);

   assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> !cpu_irq_o);

   // R2 / R3: a low-bank state bit only falls after a low-bank clear write.
   assert_state_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (|($past(st_lo) & ~st_lo)) |->
      $past(bus_valid_i && bus_write_i && bus_addr_i == ADDR_W'(OFS_LO_CLR)));

   assert_enable_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_valid_i && bus_write_i && bus_addr_i == ADDR_W'(OFS_LO_EN)) |->
      (en_lo == ($past(bus_wdata_i) | CASC_MASK)));

   assert_cascade_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_valid_i && !bus_write_i && bus_addr_i == ADDR_W'(OFS_LO_EN)) |->
      ((bus_rdata_o & CASC_MASK) == CASC_MASK));

   assert_clear_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_valid_i && !bus_write_i && bus_addr_i == ADDR_W'(OFS_LO_CLR)) |->
      (bus_rdata_o == '0));

   assert_idle_rdata_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bus_valid_i && !bus_write_i) |-> (bus_rdata_o == '0));

endmodule

bind edgelvl_irqc eli_checker #(
   .LINES     (LINES),
   .ADDR_W    (ADDR_W),
   .CASC_MASK (CASC_MASK)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_valid_i (bus_valid_i),
   .bus_write_i (bus_write_i),
   .bus_addr_i  (bus_addr_i),
   .bus_wdata_i (bus_wdata_i),
   .bus_rdata_o (bus_rdata_o),
   .cpu_irq_o   (cpu_irq_o),
   .st_lo       (st_lo),
   .en_lo       (en_lo)
);

// File: tb/edgelvl_irqc_tb.sv
module edgelvl_irqc_tb;

   localparam logic [31:0] CASC = 32'h1000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] irq_lo = '0;
   logic [31:0] irq_hi = '0;
   logic        cascade = 1'b0;
   logic        valid = 1'b0;
   logic        write = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        cpu_irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   edgelvl_irqc u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .irq_lo_i    (irq_lo),
      .irq_hi_i    (irq_hi),
      .cascade_i   (cascade),
      .bus_valid_i (valid),
      .bus_write_i (write),
      .bus_addr_i  (addr),
      .bus_wdata_i (wdata),
      .bus_rdata_o (rdata),
      .cpu_irq_o   (cpu_irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      valid = 1'b1; write = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      valid = 1'b0; write = 1'b0; wdata = '0;
   endtask

   task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      valid = 1'b1; write = 1'b0; addr = a;
      @(negedge clk);
      valid = 1'b0;
      d = rdata;
   endtask

   task automatic settle();
      repeat (6) @(negedge clk);
   endtask

   task automatic pulse_lo(input int b);
      @(negedge clk);
      irq_lo[b] = 1'b1;
      repeat (4) @(negedge clk);
      irq_lo[b] = 1'b0;
      settle();
   endtask

   task automatic t_reset();
      logic [31:0] v;
      bus_rd(8'h20, v); chk("R1 low state", v, 32'h0);
      bus_rd(8'h24, v); chk("R1 low enable", v, CASC);
      bus_rd(8'h2c, v); chk("R1 low level", v, 32'h0);
      bus_rd(8'h10, v); chk("R1 high state", v, 32'h0);
      bus_rd(8'h14, v); chk("R1 high enable", v, 32'h0);
      chk("R1 cpu_irq", {31'h0, cpu_irq}, 32'h0);
   endtask

   task automatic t_edge();
      logic [31:0] v;
      pulse_lo(3);
      bus_rd(8'h20, v); chk("R2 masked edge latched", v, 32'h8);
      chk("R2 disabled no irq", {31'h0, cpu_irq}, 32'h0);
      @(negedge clk); irq_lo[21] = 1'b1;
      settle();
      bus_rd(8'h20, v); chk("R2 level position reads 0", v, 32'h8);
      irq_lo[21] = 1'b0;
      settle();
   endtask

   task automatic t_enable();
      logic [31:0] v;
      bus_wr(8'h24, 32'h8);
      bus_rd(8'h24, v); chk("R7 enable readback", v, 32'h8 | CASC);
      settle();
      chk("R6 irq on enabled edge", {31'h0, cpu_irq}, 32'h1);
      bus_wr(8'h24, 32'h0);
      settle();
      chk("R6 irq drops on disable", {31'h0, cpu_irq}, 32'h0);
      bus_rd(8'h20, v); chk("R6 state kept when disabled", v, 32'h8);
   endtask

   task automatic t_clear();
      logic [31:0] v;
      pulse_lo(5);
      bus_rd(8'h20, v); chk("R2 two edges", v, 32'h28);
      bus_wr(8'h28, 32'h20);
      bus_rd(8'h20, v); chk("R3 partial clear", v, 32'h8);
      bus_wr(8'h28, 32'h8);
      bus_rd(8'h20, v); chk("R3 full clear", v, 32'h0);
   endtask

   task automatic t_coincident();
      logic [31:0] v;
      pulse_lo(7);
      bus_rd(8'h20, v); chk("R4 precondition", v, 32'h80);
      @(negedge clk); irq_lo[7] = 1'b1;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      valid = 1'b1; write = 1'b1; addr = 8'h28; wdata = 32'h80;
      @(negedge clk);
      valid = 1'b0; write = 1'b0; wdata = '0;
      bus_rd(8'h20, v); chk("R4 edge beats clear", v, 32'h80);
      irq_lo[7] = 1'b0;
      bus_wr(8'h28, 32'h80);
      bus_rd(8'h20, v); chk("R3 clear after coincident", v, 32'h0);
   endtask

   task automatic t_level();
      logic [31:0] v;
      bus_wr(8'h24, 32'h0040_0000);
      @(negedge clk); irq_lo[22] = 1'b1;
      settle();
      bus_rd(8'h2c, v); chk("R5 level readback", v, 32'h0040_0000);
      chk("R5 enabled level irq", {31'h0, cpu_irq}, 32'h1);
      bus_rd(8'h20, v); chk("R5 level not latched", v, 32'h0);
      irq_lo[22] = 1'b0;
      settle();
      chk("R5 irq follows line down", {31'h0, cpu_irq}, 32'h0);
      bus_wr(8'h24, 32'h0);
      irq_lo[23] = 1'b1;
      settle();
      chk("R5 disabled level no irq", {31'h0, cpu_irq}, 32'h0);
      bus_rd(8'h2c, v); chk("R5 disabled level visible", v, 32'h0080_0000);
      irq_lo[23] = 1'b0;
      settle();
   endtask

   task automatic t_high();
      logic [31:0] v;
      @(negedge clk); irq_hi[25] = 1'b1;
      repeat (4) @(negedge clk);
      irq_hi[25] = 1'b0;
      settle();
      bus_rd(8'h10, v); chk("R8 high edge latched", v, 32'h0200_0000);
      chk("R8 high disabled no irq", {31'h0, cpu_irq}, 32'h0);
      bus_wr(8'h14, 32'h0200_0000);
      bus_rd(8'h14, v); chk("R8 high enable", v, 32'h0200_0000);
      settle();
      chk("R8 high irq", {31'h0, cpu_irq}, 32'h1);
      bus_wr(8'h18, 32'h0200_0000);
      bus_rd(8'h10, v); chk("R8 high clear", v, 32'h0);
      settle();
      chk("R8 high irq cleared", {31'h0, cpu_irq}, 32'h0);
      irq_hi[0] = 1'b1;
      settle();
      bus_rd(8'h1c, v); chk("R8 high level", v, 32'h1);
      irq_hi[0] = 1'b0;
      bus_wr(8'h14, 32'h0);
      bus_wr(8'h18, 32'hffff_ffff);
      settle();
   endtask

   task automatic t_cascade();
      logic [31:0] v;
      bus_wr(8'h24, 32'h0);
      bus_rd(8'h24, v); chk("R9 cascade stays enabled", v, CASC);
      @(negedge clk); cascade = 1'b1;
      settle();
      bus_rd(8'h2c, v); chk("R9 cascade on line 28", v, CASC);
      chk("R9 cascade irq", {31'h0, cpu_irq}, 32'h1);
      cascade = 1'b0;
      settle();
      chk("R9 cascade irq drops", {31'h0, cpu_irq}, 32'h0);
   endtask

   task automatic t_bus();
      logic [31:0] v;
      pulse_lo(1);
      bus_rd(8'h28, v); chk("R10 clear reads 0", v, 32'h0);
      bus_rd(8'h30, v); chk("R10 unmapped reads 0", v, 32'h0);
      bus_wr(8'h20, 32'hffff_ffff);
      bus_rd(8'h20, v); chk("R10 state write ignored", v, 32'h2);
      bus_wr(8'h2c, 32'hffff_ffff);
      bus_rd(8'h2c, v); chk("R10 level write ignored", v, 32'h0);
      bus_wr(8'h30, 32'hffff_ffff);
      bus_rd(8'h24, v); chk("R10 unmapped write ignored", v, CASC);
      @(negedge clk);
      chk("R10 idle rdata zero", rdata, 32'h0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      bus_wr(8'h24, 32'h0);
      bus_wr(8'h28, 32'hffff_ffff);
      t_edge();
      t_enable();
      t_clear();
      t_coincident();
      t_level();
      t_high();
      t_cascade();
      t_bus();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog (all requirements): actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule